// File: doc/BRIEF.md
# Oscillator Frequency Calibration Counter

This block checks how fast an internal low-frequency oscillator (nominally 500 kHz) really runs, using an accurate 48 MHz reference clock as the ruler. A start pulse arms a measurement. The slow clock is synchronised into the reference domain and its rising edges are detected there. The first edge after arming opens a window. The window closes on the edge that ends ten full slow-clock periods. The reference cycles inside the window form a 12-bit count, which saturates instead of wrapping. A trimmed oscillator gives a count of 960.

When a measurement completes, the count is latched. A corrected divisor for the watchdog timebase is then computed as the nominal divisor scaled by count/960, rounded to the nearest integer. Until the next measurement completes, both the latched count and the divisor keep their previous values.

A byte-wide read path shares one register index between two things, and a tune-enable input picks which one is visible. With tune-enable high, the index returns the top four bits of the count. With tune-enable low, it returns a writable pin-function select register. The count, the divisor and the busy and done status are also available as plain outputs. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `osc_cal_counter`

## Requirements
- R1: After reset, count_o is 0, divisor_o equals NOM_DIV (500), busy_o and done_o are 0, and the pin-select register reads 0x00.
- R2: After a start pulse, the window opens on the first synchronised rising edge of slow_clk_i and closes on the eleventh. count_o then equals the number of reference cycles in those 10 slow periods (10 × period in reference cycles).
- R3: If the window holds more than 4095 reference cycles, the count stops at 4095 instead of wrapping.
- R4: busy_o goes high in the cycle after start_i and falls when the window closes. done_o is cleared in the cycle after start_i, is set when the window closes, and then stays set.
- R5: On completion, divisor_o becomes (NOM_DIV × count + 480) / 960 in integer arithmetic. It changes at no other time.
- R6: While a measurement is in progress, count_o, divisor_o and the read data keep the previous completed result.
- R7: A start pulse during a measurement discards the partial window and re-arms. The new result depends only on edges after the restart.
- R8: With tune_en_i = 1, rd_data_o is {4'b0000, count[11:8]}.
- R9: With tune_en_i = 0, rd_data_o is the pin-select register. A write with wr_en_i = 1 stores wr_data_i[7:1]. Bit 0 is reserved and always reads 0. Writes made while tune_en_i = 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (48 MHz in the system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk_i | input | 1 | Oscillator under calibration, asynchronous to clk |
| start_i | input | 1 | One-cycle pulse that arms or restarts a measurement |
| tune_en_i | input | 1 | Selects the count nibble (1) or the pin-select register (0) on the shared index |
| wr_en_i | input | 1 | Write strobe for the shared index |
| wr_data_i | input | 8 | Write data for the pin-select register |
| rd_data_o | output | 8 | Read data of the shared index |
| count_o | output | 12 | Last completed measurement |
| divisor_o | output | 16 | Corrected watchdog divisor |
| busy_o | output | 1 | Measurement armed or running |
| done_o | output | 1 | Sticky flag: a measurement has completed since the last start |

## Verification
The bench drives slow clocks whose period is an exact number of reference cycles. For each one, it checks the exact count and the rounded divisor. An off-by-one error in where the window opens or closes would show up as 9 or 11 periods, or as one cycle too few or too many. Wrong rounding would show up as 520 instead of 521 for a count of 1000. A very slow clock tests saturation: a counter that wraps would report a small count and a small divisor. The bench also reads the outputs during a measurement and after a restart, to catch results that leak out early or partial windows that survive a restart. On the shared index, it checks that bit 0 is reserved and that writes made while the count is selected are dropped, so that a design that decodes the write without tune-enable would corrupt the pin-select value.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_ARM  = 2'd1,
    WIN_RUN  = 2'd2
  } win_state_e;
endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-1:0], async_i};
  end

  assign rise_o = sync_q[STAGES-1] & ~sync_q[STAGES];

  // R2: a rising edge is a single-cycle event
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/osc_win_counter.sv
module osc_win_counter
  import osc_cal_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int WIN_PERIODS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rise_i,
  output logic             cap_o,
  output logic [CNT_W-1:0] meas_o,
  output logic [CNT_W-1:0] result_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int EW = $clog2(WIN_PERIODS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [EW-1:0] LAST_EDGE = EW'(WIN_PERIODS - 1);

  win_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, cnt_inc, result_q;
  logic [EW-1:0]    edges_q;
  logic             done_q;

  assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
  assign cap_o   = (state_q == WIN_RUN) && rise_i && (edges_q == LAST_EDGE) && !start_i;
  assign meas_o  = cnt_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WIN_IDLE;
      cnt_q    <= '0;
      edges_q  <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else if (start_i) begin
      state_q <= WIN_ARM;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        WIN_ARM: begin
          if (rise_i) begin
            state_q <= WIN_RUN;
            cnt_q   <= '0;
            edges_q <= '0;
          end
        end
        WIN_RUN: begin
          cnt_q <= cnt_inc;
          if (rise_i) begin
            if (edges_q == LAST_EDGE) begin
              state_q  <= WIN_IDLE;
              result_q <= cnt_inc;
              done_q   <= 1'b1;
            end else begin
              edges_q <= edges_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign result_o = result_q;
  assign busy_o   = (state_q != WIN_IDLE);
  assign done_o   = done_q;

  // R3
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WIN_RUN && cnt_q == CNT_MAX && !start_i) |=> cnt_q == CNT_MAX);
  // R4
  close_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o |=> (!busy_o && done_o));
  // R4
  start_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_o && !done_o));
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_o |=> $stable(result_o));
endmodule

// File: rtl/osc_div_calc.sv
module osc_div_calc #(
  parameter int CNT_W     = 12,
  parameter int DIV_W     = 16,
  parameter int IDEAL_CNT = 960,
  parameter int NOM_DIV   = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] meas_i,
  output logic [DIV_W-1:0] div_o
);
  localparam int PROD_W = DIV_W + CNT_W + 1;
  localparam logic [PROD_W-1:0] NOM_P  = PROD_W'(NOM_DIV);
  localparam logic [PROD_W-1:0] IDEAL_P = PROD_W'(IDEAL_CNT);
  localparam logic [PROD_W-1:0] HALF_P  = PROD_W'(IDEAL_CNT / 2);

  logic [PROD_W-1:0] prod, quot;
  logic [DIV_W-1:0]  div_q;

  assign prod = NOM_P * PROD_W'(meas_i) + HALF_P;
  assign quot = prod / IDEAL_P;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     div_q <= DIV_W'(NOM_DIV);
    else if (cap_i) div_q <= quot[DIV_W-1:0];
  end

  assign div_o = div_q;

  // R5
  div_only_on_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(div_o));
endmodule

// File: rtl/osc_reg_alias.sv
module osc_reg_alias #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tune_en_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [7:0]       rd_data_o
);
  localparam int HI_W = CNT_W - 8;

  logic [7:0] pinsel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pinsel_q <= 8'h00;
    else if (wr_en_i && !tune_en_i)  pinsel_q <= {wr_data_i[7:1], 1'b0};
  end

  assign rd_data_o = tune_en_i ? {{(8-HI_W){1'b0}}, count_i[CNT_W-1:8]} : pinsel_q;

  // R8
  nibble_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tune_en_i |-> rd_data_o[7:HI_W] == '0);
  // R9
  reserved_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tune_en_i |-> !rd_data_o[0]);
  // R9
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tune_en_i |=> $stable(pinsel_q));
endmodule

// File: rtl/osc_cal_counter.sv
module osc_cal_counter #(
  parameter int CNT_W       = 12,
  parameter int WIN_PERIODS = 10,
  parameter int IDEAL_CNT   = 960,
  parameter int DIV_W       = 16,
  parameter int NOM_DIV     = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_clk_i,
  input  logic             start_i,
  input  logic             tune_en_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  output logic [7:0]       rd_data_o,
  output logic [CNT_W-1:0] count_o,
  output logic [DIV_W-1:0] divisor_o,
  output logic             busy_o,
  output logic             done_o
);
  logic             rise;
  logic             cap;
  logic [CNT_W-1:0] meas;

  osc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(slow_clk_i), .rise_o(rise)
  );

  osc_win_counter #(.CNT_W(CNT_W), .WIN_PERIODS(WIN_PERIODS)) u_win (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rise_i(rise),
    .cap_o(cap), .meas_o(meas), .result_o(count_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  osc_div_calc #(.CNT_W(CNT_W), .DIV_W(DIV_W), .IDEAL_CNT(IDEAL_CNT),
                 .NOM_DIV(NOM_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .meas_i(meas), .div_o(divisor_o)
  );

  osc_reg_alias #(.CNT_W(CNT_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .tune_en_i(tune_en_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .count_i(count_o), .rd_data_o(rd_data_o)
  );
endmodule

// File: tb/osc_cal_counter_tb_top.sv
`timescale 1ns/1ps
module osc_cal_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_clk = 1'b0;
  logic        start_i = 1'b0;
  logic        tune_en_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_data_i = 8'h00;
  logic [7:0]  rd_data_o;
  logic [11:0] count_o;
  logic [15:0] divisor_o;
  logic        busy_o, done_o;

  int checks = 0;
  int failures = 0;
  int slow_half = 48;
  int cycles = 0;

  always #10 clk = ~clk;

  osc_cal_counter dut_i (
    .clk(clk), .rst_n(rst_n), .slow_clk_i(slow_clk), .start_i(start_i),
    .tune_en_i(tune_en_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .count_o(count_o), .divisor_o(divisor_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  initial begin : slow_gen
    int ph = 0;
    forever begin
      @(negedge clk);
      ph++;
      if (ph >= slow_half) begin
        ph = 0;
        slow_clk = ~slow_clk;
      end
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=150000 cycles", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_div(input int c);
    return (500 * c + 480) / 960;
  endfunction

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done_o && n < 30000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " completion"}, int'(done_o), 1);
  endtask

  task automatic t_reset_state();
    chk("R1 count", int'(count_o), 0);
    chk("R1 divisor", int'(divisor_o), 500);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    tune_en_i = 1'b0;
    #1 chk("R1 pinsel", int'(rd_data_o), 0);
  endtask

  task automatic t_measure(input int half, input int exp_cnt, input string req);
    slow_half = half;
    repeat (4) @(negedge clk);
    pulse_start();
    chk("R4 busy after start", int'(busy_o), 1);
    chk("R4 done cleared", int'(done_o), 0);
    wait_done(req);
    chk({req, " count"}, int'(count_o), exp_cnt);
    chk("R5 divisor", int'(divisor_o), exp_div(exp_cnt));
    chk("R4 busy low at end", int'(busy_o), 0);
    repeat (3) @(negedge clk);
    chk("R4 done sticky", int'(done_o), 1);
  endtask

  task automatic t_hold_and_restart();
    int prev_cnt, prev_div;
    prev_cnt = int'(count_o);
    prev_div = int'(divisor_o);
    slow_half = 50;
    repeat (4) @(negedge clk);
    pulse_start();
    repeat (300) @(negedge clk);
    chk("R6 count held", int'(count_o), prev_cnt);
    chk("R6 divisor held", int'(divisor_o), prev_div);
    tune_en_i = 1'b1;
    #1 chk("R6 read held", int'(rd_data_o), prev_cnt >> 8);
    tune_en_i = 1'b0;
    chk("R6 busy mid window", int'(busy_o), 1);
    pulse_start();
    chk("R7 done low after restart", int'(done_o), 0);
    wait_done("R7");
    chk("R7 count after restart", int'(count_o), 1000);
    chk("R7 divisor after restart", int'(divisor_o), exp_div(1000));
  endtask

  task automatic t_alias();
    tune_en_i = 1'b1;
    #1 chk("R8 nibble", int'(rd_data_o), int'(count_o) >> 8);
    tune_en_i = 1'b0;
    @(negedge clk) begin wr_en_i = 1'b1; wr_data_i = 8'hA5; end
    @(negedge clk) wr_en_i = 1'b0;
    chk("R9 pinsel write, bit0 reserved", int'(rd_data_o), 8'hA4);
    tune_en_i = 1'b1;
    @(negedge clk) begin wr_en_i = 1'b1; wr_data_i = 8'h3C; end
    @(negedge clk) wr_en_i = 1'b0;
    chk("R8 count unaffected by write", int'(rd_data_o), int'(count_o) >> 8);
    tune_en_i = 1'b0;
    #1 chk("R9 write ignored when tune_en", int'(rd_data_o), 8'hA4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_measure(48, 960, "R2 nominal");
    t_alias();
    t_measure(45, 900, "R2 fast osc");
    t_hold_and_restart();
    t_measure(500, 4095, "R3 saturation");
    tune_en_i = 1'b1;
    #1 chk("R8 saturated nibble", int'(rd_data_o), 15);
    tune_en_i = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule